// File: doc/BRIEF.md
# Bus Master Memory Strobe Generator

This block lets an on-chip agent act as the master of memory cycles on a parallel expansion bus. A request carries an address, a read/write flag and, for writes, the data to store. The block puts the address on the bus for one full clock with every command strobe idle. It then pulls the matching active-low command strobe low for a fixed number of clocks. It releases the strobe while still holding the address for one more clock, and in that clock it pulses `done`.

Next to the general read and write strobes, the block drives a second, restricted strobe pair. These strobes follow the general strobes only when the latched address lies in the first megabyte of the space, that is, when every address bit from bit 20 upward is zero. Slaves that decode only the low megabyte use the restricted pair. Every other slave uses the general pair.

For a read, the block samples the bus data on the last clock of the command phase and holds that value on `rd_data` until the next read completes. New requests are taken only while `ready` is high.

Top module: `bus_master_strobe`

## Requirements
- R1: While reset is applied and on the first clock after it, all four strobes are high, `bus_addr_en`, `bus_data_oe` and `done` are low, `ready` is high and `rd_data` is zero.
- R2: The block accepts a request only when `ready` and `req_valid` are both high at a clock edge. `ready` stays low from the clock after acceptance until the transfer ends. While the block is busy it ignores `req_valid`, `req_addr`, `req_write` and `req_wdata`, and `bus_addr` holds the accepted address.
- R3: In the clock after acceptance, `bus_addr_en` is high, `bus_addr` equals the accepted address and every strobe is still high.
- R4: For a read (`req_write` = 0), `mem_rd_n` is low for exactly CMD_CYCLES consecutive clocks right after the address clock, and `mem_wr_n` stays high.
- R5: For a write (`req_write` = 1), `mem_wr_n` is low for exactly CMD_CYCLES consecutive clocks right after the address clock, and `mem_rd_n` stays high. From the address clock through the final clock, `bus_data_oe` is high and `bus_wdata` equals the accepted write data.
- R6: `low_rd_n` and `low_wr_n` copy `mem_rd_n` and `mem_wr_n` when address bits 23:20 of the accepted address are all zero. For any other address they stay high.
- R7: `mem_rd_n` and `mem_wr_n` are never low together. A restricted strobe is never low unless its general strobe is low too.
- R8: In the clock after the command phase, every strobe is high, `bus_addr_en` is still high with the address unchanged, and `done` is high for that single clock. In the next clock `ready` is high again and `bus_addr_en` is low.
- R9: A read loads `rd_data` with the value on `bus_rdata` at the clock edge that ends the command phase. `rd_data` keeps that value through later writes until another read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Block idle, will take a request |
| done | output | 1 | One-clock pulse when a transfer ends |
| rd_data | output | 16 | Last read data captured |
| bus_addr | output | 24 | Address lines toward the bus |
| bus_addr_en | output | 1 | Address output enable |
| bus_wdata | output | 16 | Data lines toward the bus |
| bus_data_oe | output | 1 | Data output enable (writes) |
| bus_rdata | input | 16 | Data lines from the bus |
| mem_rd_n | output | 1 | General memory read strobe, active low |
| mem_wr_n | output | 1 | General memory write strobe, active low |
| low_rd_n | output | 1 | Low-megabyte read strobe, active low |
| low_wr_n | output | 1 | Low-megabyte write strobe, active low |

## Verification
The bench builds the block with a 24-bit address, 16-bit data and CMD_CYCLES = 3. With a command phase longer than two clocks, the checks can tell a strobe held for the wrong number of clocks apart from the right one. They can also tell a read capture on the first or a middle command clock apart from one on the last. The directed addresses 0x000000, 0x0FFFFF, 0x100000 and 0xFFFFFF fall on both sides of the low-megabyte edge. Some transfers keep `req_valid` high with changed request fields while the block is busy, so the checks cover requests arriving mid-transfer.

// File: rtl/mstb_pkg.sv
package mstb_pkg;

    // Default geometry of the bus
    localparam int unsigned MSTB_ADDR_W     = 24;
    localparam int unsigned MSTB_DATA_W     = 16;
    localparam int unsigned MSTB_LOW_BIT    = 20;
    localparam int unsigned MSTB_CMD_CYCLES = 2;

    // Transfer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CMD  = 2'd2,
        ST_END  = 2'd3
    } mstb_state_e;

    // Strobe bundle, all active low
    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic low_rd_n;
        logic low_wr_n;
    } mstb_strobe_t;

    // Output-enable bundle
    typedef struct packed {
        logic addr_en;
        logic data_oe;
    } mstb_drive_t;

    localparam mstb_strobe_t MSTB_STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1,
                                                  low_rd_n: 1'b1, low_wr_n: 1'b1};

    // True when state is one where the address is on the bus
    function automatic logic mstb_addr_phase(input mstb_state_e st);
        return (st == ST_ADDR) || (st == ST_CMD) || (st == ST_END);
    endfunction

endpackage

// File: rtl/mstb_seq.sv
module mstb_seq
    import mstb_pkg::*;
#(
    parameter int unsigned CMD_CYCLES = MSTB_CMD_CYCLES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output mstb_state_e state,
    output logic        accept,
    output logic        last_cmd
);

    localparam int unsigned CNT_W = (CMD_CYCLES < 2) ? 1 : $clog2(CMD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign last_cmd = (state == ST_CMD) && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) state <= ST_ADDR;
                end
                ST_ADDR: begin
                    state <= ST_CMD;
                    cnt   <= '0;
                end
                ST_CMD: begin
                    if (last_cmd) state <= ST_END;
                    else          cnt   <= cnt + 1'b1;
                end
                ST_END: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command phase can only be entered from the address phase
    AST_CMD_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && $past(state) != ST_CMD) |-> $past(state) == ST_ADDR); // R3

    // The end phase lasts one clock and returns to idle
    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_END) |=> (state == ST_IDLE)); // R8

endmodule

// File: rtl/mstb_dpath.sv
module mstb_dpath
    import mstb_pkg::*;
#(
    parameter int unsigned ADDR_W  = MSTB_ADDR_W,
    parameter int unsigned DATA_W  = MSTB_DATA_W,
    parameter int unsigned LOW_BIT = MSTB_LOW_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              last_cmd,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              lat_write,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              low_hit,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned HI_W = ADDR_W - LOW_BIT;

    logic [HI_W-1:0] addr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        rd_data <= '0;
        else if (last_cmd && !lat_write) rd_data <= bus_rdata;
    end

    // Low-window decode on the held address
    assign addr_hi = lat_addr[ADDR_W-1:LOW_BIT];
    assign low_hit = (addr_hi == '0);

    // Held request must not move while a transfer runs
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (last_cmd) |-> ($stable(lat_addr) && $stable(lat_write))); // R2

endmodule

// File: rtl/mstb_strobe.sv
module mstb_strobe
    import mstb_pkg::*;
(
    input  mstb_state_e  state,
    input  logic         lat_write,
    input  logic         low_hit,
    output mstb_strobe_t strb,
    output mstb_drive_t  drv
);

    logic cmd_on;

    assign cmd_on = (state == ST_CMD);

    always_comb begin
        strb          = MSTB_STROBE_IDLE;
        strb.rd_n     = ~(cmd_on & ~lat_write);
        strb.wr_n     = ~(cmd_on &  lat_write);
        strb.low_rd_n = strb.rd_n | ~low_hit;
        strb.low_wr_n = strb.wr_n | ~low_hit;
    end

    always_comb begin
        drv.addr_en = mstb_addr_phase(state);
        drv.data_oe = mstb_addr_phase(state) & lat_write;
    end

endmodule

// File: rtl/bus_master_strobe.sv
module bus_master_strobe
    import mstb_pkg::*;
#(
    parameter int unsigned ADDR_W     = MSTB_ADDR_W,
    parameter int unsigned DATA_W     = MSTB_DATA_W,
    parameter int unsigned LOW_BIT    = MSTB_LOW_BIT,
    parameter int unsigned CMD_CYCLES = MSTB_CMD_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_en,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              low_rd_n,
    output logic              low_wr_n
);

    mstb_state_e  state;
    logic         accept;
    logic         last_cmd;
    logic         lat_write;
    logic         low_hit;
    mstb_strobe_t strb;
    mstb_drive_t  drv;

    mstb_seq #(
        .CMD_CYCLES (CMD_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .state     (state),
        .accept    (accept),
        .last_cmd  (last_cmd)
    );

    mstb_dpath #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LOW_BIT (LOW_BIT)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .last_cmd  (last_cmd),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_rdata (bus_rdata),
        .lat_write (lat_write),
        .lat_addr  (bus_addr),
        .lat_wdata (bus_wdata),
        .low_hit   (low_hit),
        .rd_data   (rd_data)
    );

    mstb_strobe u_strobe (
        .state     (state),
        .lat_write (lat_write),
        .low_hit   (low_hit),
        .strb      (strb),
        .drv       (drv)
    );

    assign mem_rd_n    = strb.rd_n;
    assign mem_wr_n    = strb.wr_n;
    assign low_rd_n    = strb.low_rd_n;
    assign low_wr_n    = strb.low_wr_n;
    assign bus_addr_en = drv.addr_en;
    assign bus_data_oe = drv.data_oe;
    assign ready       = (state == ST_IDLE);
    assign done        = (state == ST_END);

    // A strobe may only fall after a full clock of driven, steady address
    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_rd_n) || $fell(mem_wr_n)) |->
            ($past(bus_addr_en) && $stable(bus_addr))); // R3

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n)); // R7

    AST_LOW_RD_QUAL: assert property (@(posedge clk) disable iff (rst)
        !low_rd_n |-> !mem_rd_n); // R7

    AST_LOW_WR_QUAL: assert property (@(posedge clk) disable iff (rst)
        !low_wr_n |-> !mem_wr_n); // R7

    AST_LOW_DECODE: assert property (@(posedge clk) disable iff (rst)
        ((!mem_rd_n || !mem_wr_n) && bus_addr[ADDR_W-1:LOW_BIT] == '0) |->
            (low_rd_n == mem_rd_n && low_wr_n == mem_wr_n)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && ready)); // R8

    AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_en && $past(bus_addr_en)) |-> $stable(bus_addr)); // R2

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> !ready); // R2

endmodule

// File: tb/test_bus_master_strobe.sv
module test_bus_master_strobe;

    localparam int unsigned AW   = 24;
    localparam int unsigned DW   = 16;
    localparam int unsigned NCMD = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          ready;
    logic          done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_en;
    logic [DW-1:0] bus_wdata;
    logic          bus_data_oe;
    logic [DW-1:0] bus_rdata;
    logic          mem_rd_n;
    logic          mem_wr_n;
    logic          low_rd_n;
    logic          low_wr_n;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;
    logic [DW-1:0] exp_rd = '0;

    always #4 clk = ~clk;

    bus_master_strobe #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .LOW_BIT    (20),
        .CMD_CYCLES (NCMD)
    ) i_bus_master_strobe (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ready       (ready),
        .done        (done),
        .rd_data     (rd_data),
        .bus_addr    (bus_addr),
        .bus_addr_en (bus_addr_en),
        .bus_wdata   (bus_wdata),
        .bus_data_oe (bus_data_oe),
        .bus_rdata   (bus_rdata),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n),
        .low_rd_n    (low_rd_n),
        .low_wr_n    (low_wr_n)
    );

    function automatic logic in_low(input logic [AW-1:0] a);
        return a[AW-1:20] == '0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit noisy);
        logic [DW-1:0] v;
        logic          lo;
        lo = in_low(a);
        v  = DW'($urandom);
        @(negedge clk);
        chk("R2 ready before request", ready, 1'b1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        bus_rdata = DW'($urandom);
        @(negedge clk);
        // address phase
        chk("R3 addr_en", bus_addr_en, 1'b1);
        chk("R3 addr", bus_addr, a);
        chk("R3 rd_n idle", mem_rd_n, 1'b1);
        chk("R3 wr_n idle", mem_wr_n, 1'b1);
        chk("R2 ready low", ready, 1'b0);
        if (wr) begin
            chk("R5 data_oe addr phase", bus_data_oe, 1'b1);
            chk("R5 wdata addr phase", bus_wdata, d);
        end
        if (noisy) begin
            req_addr  = ~a;
            req_write = ~wr;
            req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < NCMD; i++) begin
            @(negedge clk);
            chk(wr ? "R5 rd_n high" : "R4 rd_n low", mem_rd_n, wr);
            chk(wr ? "R5 wr_n low" : "R4 wr_n high", mem_wr_n, !wr);
            chk("R6 low_rd_n", low_rd_n, !(!wr && lo));
            chk("R6 low_wr_n", low_wr_n, !(wr && lo));
            chk("R2 addr held", bus_addr, a);
            chk("R2 ready busy", ready, 1'b0);
            if (wr) chk("R5 wdata", bus_wdata, d);
            bus_rdata = (i == NCMD - 1) ? v : DW'($urandom);
        end
        @(negedge clk);
        // end phase
        bus_rdata = ~v;
        req_valid = 1'b0;
        if (!wr) exp_rd = v;
        chk("R8 done", done, 1'b1);
        chk("R8 rd_n released", mem_rd_n, 1'b1);
        chk("R8 wr_n released", mem_wr_n, 1'b1);
        chk("R8 addr_en", bus_addr_en, 1'b1);
        chk("R8 addr", bus_addr, a);
        chk("R5 data_oe end", bus_data_oe, wr);
        chk("R9 rd_data captured", rd_data, exp_rd);
        @(negedge clk);
        chk("R8 done dropped", done, 1'b0);
        chk("R8 ready back", ready, 1'b1);
        chk("R8 addr_en off", bus_addr_en, 1'b0);
        chk("R9 rd_data held", rd_data, exp_rd);
    endtask

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        bus_rdata = '0;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rd_n", mem_rd_n, 1'b1);
        chk("R1 low_wr_n", low_wr_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_n", mem_rd_n, 1'b1);
        chk("R1 wr_n", mem_wr_n, 1'b1);
        chk("R1 low_rd_n", low_rd_n, 1'b1);
        chk("R1 low_wr_n", low_wr_n, 1'b1);
        chk("R1 ready", ready, 1'b1);
        chk("R1 done", done, 1'b0);
        chk("R1 addr_en", bus_addr_en, 1'b0);
        chk("R1 data_oe", bus_data_oe, 1'b0);
        chk("R1 rd_data", rd_data, '0);

        // directed corners around the low-megabyte edge
        run_txn(1'b0, 24'h000000, 16'h0000, 1'b0);
        run_txn(1'b0, 24'h0FFFFF, 16'h0000, 1'b1);
        run_txn(1'b1, 24'h100000, 16'hA5A5, 1'b0);
        run_txn(1'b1, 24'hFFFFFF, 16'h5A5A, 1'b1);
        run_txn(1'b0, 24'h100000, 16'h0000, 1'b0);
        run_txn(1'b1, 24'h0ABCDE, 16'h1234, 1'b0);
        run_txn(1'b0, 24'hF00000, 16'h0000, 1'b1);

        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if ($urandom % 2) a[AW-1:20] = '0;
            run_txn(1'($urandom), a, DW'($urandom), 1'($urandom));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule